// File: doc/BRIEF.md
# Three-Wire Microcontroller Bus Slave with Control and Status Registers

This block is the control port of an audio converter. A host microcontroller reaches it over three lines: a bus clock, a mode line and a data line. The data line is split at the block edge into an input, an output and an output enable for the pad. While the mode line is low, the host sends an 8-pulse burst that selects a device. While the mode line is high, the host moves data bytes. The block sits in a faster system clock domain. It synchronises the three lines and acts on their edges.

A selected device takes two kinds of transfer. In a write, one register byte names a 7-bit register and two data bytes carry a 16-bit value. In a read, the host first announces the register (prepare read) and then selects the device again with the read mode. The block then returns three bytes: the echoed register address with a validity flag, the high data byte and the low data byte. Four writable control words leave the block on ports. Two 16-bit status words come in on ports and are sent back when they are read.

Top module: `mcu3w_slave`

## Requirements
- R1: After reset the control words are system 16'h0001 (bit 0 is power-on), sound 16'h0001 (bit 0 is soft mute), volume 16'h0000 and multiplex 16'h0001 (bit 0 is auto-mute enable, bit 1 is PLL reset), and the data output enable is low.
- R2: A device-select byte counts only when exactly 8 bus-clock rising edges fall within one mode-low interval. In time order its bits are: mode field bit 0, mode field bit 1, then the device address 6'b000110 from its bit 0 up to its bit 5. Mode field 01 (bit 0 = 0) selects write or prepare read and 11 selects read. Fields 00 and 10, any other device address, and bursts of any other length (such as a single wake-up pulse) select nothing, and the data bytes that follow have no effect.
- R3: After a write select, the first byte carries a 0 flag and then register address bits A6 to A0 in time order. The next two bytes carry D15..D8 and then D7..D0, most significant bit first in time. The word is stored at 00H (system), 10H (sound), 11H (volume) or 40H (multiplex).
- R4: Once a write completes, further data bytes have no effect until the device is selected again.
- R5: A write to any other register address except 7FH leaves all four control words unchanged.
- R6: A write to 7FH restores all four control words to their R1 values, whatever the data.
- R7: A register byte whose first bit is 1 latches a read pointer. A following read select returns {flag 0, A6..A0, D15..D0} in time order. The data is the interpolator status word for 18H and the input status word for 38H.
- R8: If the pointer names any other address, or no prepare read has happened since reset (pointer 00H), the read returns flag 1, the pointer address and zero data.
- R9: The data output enable is high only from the read select until the 24th bus-clock rising edge after it. A falling mode line also drops it.
- R10: The first returned bit is on the output before the first bus-clock rising edge. Each later bit appears after a bus-clock falling edge and is held until the next one.
- R11: A bus-clock rising edge that reaches the block in the same system cycle as a mode-line edge is not counted as a bit.
- R12: The returned data is the status value present when the read select completes. Later changes in the same transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_clk_i | input | 1 | bus clock from host, idle high |
| bus_mode_i | input | 1 | mode line: low for device select, high for data |
| bus_data_i | input | 1 | data line as received from the pad |
| bus_data_o | output | 1 | data bit driven during a read |
| bus_data_oe | output | 1 | pad output enable for the data line |
| stat_interp_i | input | 16 | status word returned for register 18H |
| stat_link_i | input | 16 | status word returned for register 38H |
| cfg_system_o | output | 16 | control word of register 00H |
| cfg_sound_o | output | 16 | control word of register 10H |
| cfg_volume_o | output | 16 | control word of register 11H |
| cfg_mux_o | output | 16 | control word of register 40H |

## Verification
A mode-line edge and a bus-clock rising edge can reach the block in the same system cycle, because both pass through synchronisers of equal depth. The bench provokes this by sending the usual 8 select pulses, then raising a ninth clock edge in the same time step as the mode line. It judges the result by the effect of the write that follows: the control word must take the new value, which shows the select byte was kept as an exact 8-pulse burst. The other paths are swept over every writable register, a set of unmapped addresses, and every single-bit corruption of the select byte.

// File: rtl/mcu3w_pkg.sv
// Shared constants and types of the three-wire bus slave.
// Assumes 16-bit register words and 7-bit register addresses, fixed by the protocol.
package mcu3w_pkg;
    localparam int DATA_W   = 16;
    localparam int RADDR_W  = 7;
    localparam int DEV_W    = 6;
    localparam int BYTE_W   = 8;
    localparam int TX_W     = BYTE_W + DATA_W;       // flag + address + data
    localparam int WR_REGS  = 4;

    localparam int IDX_SYS  = 0;
    localparam int IDX_SND  = 1;
    localparam int IDX_VOL  = 2;
    localparam int IDX_MUX  = 3;

    localparam logic [WR_REGS-1:0][RADDR_W-1:0] WR_ADDR =
        {7'h40, 7'h11, 7'h10, 7'h00};
    localparam logic [WR_REGS-1:0][DATA_W-1:0] WR_DEFAULT =
        {16'h0001, 16'h0000, 16'h0001, 16'h0001};

    localparam logic [RADDR_W-1:0] RESTORE_ADDR = 7'h7F;
    localparam logic [RADDR_W-1:0] STAT_A_ADDR  = 7'h18;
    localparam logic [RADDR_W-1:0] STAT_B_ADDR  = 7'h38;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_REG,
        LS_HI,
        LS_LO,
        LS_TX,
        LS_DONE
    } link_state_t;

    // Select byte in time order (bit 7 of the result is first on the wire).
    function automatic logic [BYTE_W-1:0] select_pattern(input logic [DEV_W-1:0] dev,
                                                         input logic rd);
        return {rd, 1'b1, dev[0], dev[1], dev[2], dev[3], dev[4], dev[5]};
    endfunction
endpackage

// File: rtl/mcu3w_sync.sv
// Two-flop synchroniser for W asynchronous lines, with edge pulses for the
// lowest E lines. Assumes each line stays stable for several system cycles.
module mcu3w_sync #(
    parameter int W = 3,
    parameter int E = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [E-1:0] rise_o,
    output logic [E-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [E-1:0] prev_q;

    // Two-stage capture of the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign lvl_o = sync_q;

    for (genvar g = 0; g < E; g++) begin : g_edge
        // Delayed copy used to detect a change of the synchronised level.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= INIT[g];
            else        prev_q[g] <= sync_q[g];
        end
        assign rise_o[g] =  sync_q[g] & ~prev_q[g];
        assign fall_o[g] = ~sync_q[g] &  prev_q[g];
    end
endmodule

// File: rtl/mcu3w_link.sv
// Framing engine: collects select bursts and data bytes, decodes writes and
// prepare reads, and shifts out the 24-bit read reply. Assumes synchronised
// inputs with single-cycle edge pulses; mode-line edges take priority.
module mcu3w_link
    import mcu3w_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 6'b000110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               mode_lvl,
    input  logic               mode_rise,
    input  logic               mode_fall,
    input  logic               din,
    input  logic [TX_W-1:0]    rd_word,
    output logic               wr_stb,
    output logic [RADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               prep_stb,
    output logic [RADDR_W-1:0] prep_addr,
    output logic               dout,
    output logic               oe
);
    localparam logic [BYTE_W-1:0] PAT_WR = select_pattern(DEV_ADDR, 1'b0);
    localparam logic [BYTE_W-1:0] PAT_RD = select_pattern(DEV_ADDR, 1'b1);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam int TXC_W = $clog2(TX_W + 1);
    localparam logic [TXC_W-1:0] TXC_LAST = TXC_W'(TX_W - 1);

    link_state_t         state_q;
    logic [BYTE_W-1:0]   sh_q;
    logic [BYTE_W-1:0]   sh_next;
    logic [CNT_W-1:0]    bitcnt_q;
    logic [RADDR_W-1:0]  reg_q;
    logic [BYTE_W-1:0]   hi_q;
    logic [TX_W-1:0]     tx_q;
    logic [TXC_W-1:0]    txcnt_q;
    logic                sel_wr;
    logic                sel_rd;
    logic                tx_start;

    // Incoming bit appended behind the earlier bits of the byte.
    always_comb sh_next = {sh_q[BYTE_W-2:0], din};

    // Decode of a completed select burst at the end of mode-low.
    always_comb begin
        sel_wr   = (bitcnt_q == CNT_FULL) && (sh_q == PAT_WR);
        sel_rd   = (bitcnt_q == CNT_FULL) && (sh_q == PAT_RD);
        tx_start = mode_rise && sel_rd;
    end

    // Protocol state, bit and byte collection, reply shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LS_IDLE;
            sh_q      <= '0;
            bitcnt_q  <= '0;
            reg_q     <= '0;
            hi_q      <= '0;
            tx_q      <= '0;
            txcnt_q   <= '0;
            oe        <= 1'b0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            prep_stb  <= 1'b0;
            prep_addr <= '0;
        end else begin
            wr_stb   <= 1'b0;
            prep_stb <= 1'b0;
            if (mode_fall) begin
                bitcnt_q <= '0;
                state_q  <= LS_IDLE;
                oe       <= 1'b0;
            end else if (mode_rise) begin
                bitcnt_q <= '0;
                if (sel_wr) begin
                    state_q <= LS_REG;
                end else if (sel_rd) begin
                    state_q <= LS_TX;
                    tx_q    <= rd_word;
                    txcnt_q <= '0;
                    oe      <= 1'b1;
                end else begin
                    state_q <= LS_IDLE;
                end
            end else if (sclk_rise) begin
                sh_q <= sh_next;
                if (!mode_lvl) begin
                    if (bitcnt_q != CNT_OVER) bitcnt_q <= bitcnt_q + 1'b1;
                end else if (state_q == LS_TX) begin
                    txcnt_q <= txcnt_q + 1'b1;
                    if (txcnt_q == TXC_LAST) begin
                        oe      <= 1'b0;
                        state_q <= LS_DONE;
                    end
                end else if (bitcnt_q == CNT_LAST) begin
                    bitcnt_q <= '0;
                    case (state_q)
                        LS_REG: begin
                            if (!sh_next[BYTE_W-1]) begin
                                reg_q   <= sh_next[RADDR_W-1:0];
                                state_q <= LS_HI;
                            end else begin
                                prep_addr <= sh_next[RADDR_W-1:0];
                                prep_stb  <= 1'b1;
                                state_q   <= LS_DONE;
                            end
                        end
                        LS_HI: begin
                            hi_q    <= sh_next;
                            state_q <= LS_LO;
                        end
                        LS_LO: begin
                            wr_addr <= reg_q;
                            wr_data <= {hi_q, sh_next};
                            wr_stb  <= 1'b1;
                            state_q <= LS_DONE;
                        end
                        default: state_q <= state_q;
                    endcase
                end else begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end else if (sclk_fall && state_q == LS_TX && txcnt_q != '0) begin
                tx_q <= {tx_q[TX_W-2:0], 1'b0};
            end
        end
    end

    assign dout = tx_q[TX_W-1];

    // R9: the pad is released once the host returns to device-select mode.
    p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fall |=> !oe);

    // R10: the driven bit only moves on a bus-clock falling edge or a reload.
    p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !sclk_fall && !mode_rise) |=> $stable(dout));

    // R11: at most one transaction event is produced per system cycle.
    p_single_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, prep_stb, tx_start}));
endmodule

// File: rtl/mcu3w_regs.sv
// Control word storage, restore-to-default, read pointer and reply assembly.
// Assumes single-cycle write and prepare strobes from the framing engine.
module mcu3w_regs
    import mcu3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [RADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               prep_stb,
    input  logic [RADDR_W-1:0] prep_addr,
    input  logic [DATA_W-1:0]  stat_a,
    input  logic [DATA_W-1:0]  stat_b,
    output logic [DATA_W-1:0]  cfg_sys,
    output logic [DATA_W-1:0]  cfg_snd,
    output logic [DATA_W-1:0]  cfg_vol,
    output logic [DATA_W-1:0]  cfg_mux,
    output logic [TX_W-1:0]    rd_word
);
    logic [DATA_W-1:0]  cfg_q [WR_REGS];
    logic [WR_REGS-1:0] hit;
    logic               restore;
    logic [RADDR_W-1:0] ptr_q;
    logic               ptr_ok_q;
    logic [DATA_W-1:0]  rd_data;

    assign restore = wr_stb && (wr_addr == RESTORE_ADDR);

    for (genvar g = 0; g < WR_REGS; g++) begin : g_cfg
        assign hit[g] = (wr_addr == WR_ADDR[g]);
        // One control word: default on reset or restore, new value on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || restore) cfg_q[g] <= WR_DEFAULT[g];
            else if (wr_stb && hit[g]) cfg_q[g] <= wr_data;
        end
    end

    assign cfg_sys = cfg_q[IDX_SYS];
    assign cfg_snd = cfg_q[IDX_SND];
    assign cfg_vol = cfg_q[IDX_VOL];
    assign cfg_mux = cfg_q[IDX_MUX];

    // Read pointer and its validity, set by each prepare read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            ptr_ok_q <= 1'b0;
        end else if (prep_stb) begin
            ptr_q    <= prep_addr;
            ptr_ok_q <= (prep_addr == STAT_A_ADDR) || (prep_addr == STAT_B_ADDR);
        end
    end

    // Status word selection for the reply.
    always_comb begin
        rd_data = '0;
        if (ptr_ok_q && ptr_q == STAT_A_ADDR) rd_data = stat_a;
        if (ptr_ok_q && ptr_q == STAT_B_ADDR) rd_data = stat_b;
    end

    assign rd_word = {~ptr_ok_q, ptr_q, rd_data};

    // R5: a write to an address outside the map leaves every word unchanged.
    p_unmapped_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && hit == '0 && !restore) |=>
        ($stable(cfg_sys) && $stable(cfg_snd) && $stable(cfg_vol) && $stable(cfg_mux)));

    // R6: a restore write brings every word back to its default.
    p_restore_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (cfg_sys == WR_DEFAULT[IDX_SYS] && cfg_snd == WR_DEFAULT[IDX_SND] &&
                     cfg_vol == WR_DEFAULT[IDX_VOL] && cfg_mux == WR_DEFAULT[IDX_MUX]));

    // R8: an invalid pointer always carries zero data in the reply.
    p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[TX_W-1] |-> (rd_word[DATA_W-1:0] == '0));
endmodule

// File: rtl/mcu3w_slave.sv
// Top of the three-wire bus slave: synchronises the bus lines, runs the
// framing engine and holds the register file. Assumes the bus clock half
// period spans many system clock cycles.
module mcu3w_slave
    import mcu3w_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 6'b000110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              bus_mode_i,
    input  logic              bus_data_i,
    output logic              bus_data_o,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] stat_interp_i,
    input  logic [DATA_W-1:0] stat_link_i,
    output logic [DATA_W-1:0] cfg_system_o,
    output logic [DATA_W-1:0] cfg_sound_o,
    output logic [DATA_W-1:0] cfg_volume_o,
    output logic [DATA_W-1:0] cfg_mux_o
);
    logic [2:0]         s_lvl;
    logic [1:0]         s_rise;
    logic [1:0]         s_fall;
    logic               unused_sclk_lvl;
    logic               wr_stb;
    logic [RADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0]  wr_data;
    logic               prep_stb;
    logic [RADDR_W-1:0] prep_addr;
    logic [TX_W-1:0]    rd_word;

    assign unused_sclk_lvl = s_lvl[0];

    mcu3w_sync #(.W(3), .E(2), .INIT(3'b011)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_data_i, bus_mode_i, bus_clk_i}),
        .lvl_o   (s_lvl),
        .rise_o  (s_rise),
        .fall_o  (s_fall)
    );

    mcu3w_link #(.DEV_ADDR(DEV_ADDR)) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (s_rise[0]),
        .sclk_fall (s_fall[0]),
        .mode_lvl  (s_lvl[1]),
        .mode_rise (s_rise[1]),
        .mode_fall (s_fall[1]),
        .din       (s_lvl[2]),
        .rd_word   (rd_word),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prep_stb  (prep_stb),
        .prep_addr (prep_addr),
        .dout      (bus_data_o),
        .oe        (bus_data_oe)
    );

    mcu3w_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prep_stb  (prep_stb),
        .prep_addr (prep_addr),
        .stat_a    (stat_interp_i),
        .stat_b    (stat_link_i),
        .cfg_sys   (cfg_system_o),
        .cfg_snd   (cfg_sound_o),
        .cfg_vol   (cfg_volume_o),
        .cfg_mux   (cfg_mux_o),
        .rd_word   (rd_word)
    );
endmodule

// File: tb/mcu3w_slave_tb_top.sv
// Self-checking bench: drives the bus at 256 ns half periods, offset from the
// system clock edges, and predicts every register and reply arithmetically.
module mcu3w_slave_tb_top;
    localparam int HP = 256;
    localparam logic [7:0] SEL_WR = 8'h58;
    localparam logic [7:0] SEL_RD = 8'hD8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        bmode = 1'b1;
    logic        bdin = 1'b0;
    logic        bdout;
    logic        boe;
    logic [15:0] st_a = 16'h0000;
    logic [15:0] st_b = 16'h0000;
    logic [15:0] c_sys, c_snd, c_vol, c_mux;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] exp_w [4];
    logic [6:0]  map_a [4];

    always #4 clk = ~clk;

    mcu3w_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_clk_i     (bclk),
        .bus_mode_i    (bmode),
        .bus_data_i    (bdin),
        .bus_data_o    (bdout),
        .bus_data_oe   (boe),
        .stat_interp_i (st_a),
        .stat_link_i   (st_b),
        .cfg_system_o  (c_sys),
        .cfg_sound_o   (c_snd),
        .cfg_volume_o  (c_vol),
        .cfg_mux_o     (c_mux)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg_of(input int i);
        case (i)
            0: return c_sys;
            1: return c_snd;
            2: return c_vol;
            default: return c_mux;
        endcase
    endfunction

    task automatic chk_all(input string req);
        for (int i = 0; i < 4; i++) chk(req, {16'h0, cfg_of(i)}, {16'h0, exp_w[i]});
    endtask

    task automatic set_defaults();
        exp_w[0] = 16'h0001; exp_w[1] = 16'h0001; exp_w[2] = 16'h0000; exp_w[3] = 16'h0001;
    endtask

    task automatic bus_bit(input logic b);
        bclk = 1'b0; bdin = b; #HP;
        bclk = 1'b1; #HP;
    endtask

    task automatic send_sel(input logic [7:0] v);
        bmode = 1'b0; #HP;
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        bmode = 1'b1; #HP;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        send_sel(SEL_WR);
        send_byte({1'b0, a});
        send_byte(d[15:8]);
        send_byte(d[7:0]);
    endtask

    task automatic prep(input logic [6:0] a);
        send_sel(SEL_WR);
        send_byte({1'b1, a});
    endtask

    task automatic rd(input bit chg, input logic [15:0] nv, output logic [23:0] got);
        send_sel(SEL_RD);
        chk("R9 oe at read start", {31'h0, boe}, 32'h1);
        if (chg) begin st_a = nv; st_b = nv; end
        for (int i = 23; i >= 0; i--) begin
            bclk = 1'b0; #HP;
            got[i] = bdout;
            bclk = 1'b1; #HP;
        end
    endtask

    initial begin
        logic [23:0] got;
        logic [15:0] d;
        #3;
        map_a[0] = 7'h00; map_a[1] = 7'h10; map_a[2] = 7'h11; map_a[3] = 7'h40;
        set_defaults();
        repeat (5) @(negedge clk);
        #3 rst_n = 1'b1;
        #(HP);

        // R1: reset values
        chk_all("R1 reset word");
        chk("R1 oe after reset", {31'h0, boe}, 32'h0);

        // R8: read with no prepare since reset
        rd(1'b0, 16'h0, got);
        chk("R8 read before prepare", {8'h0, got}, {8'h0, 24'h800000});
        chk("R9 oe after 24 bits", {31'h0, boe}, 32'h0);

        // R2: wake-up pulse then a valid write
        bmode = 1'b0; #HP; bus_bit(1'b1); bmode = 1'b1; #HP;
        wr(7'h11, 16'h002A); exp_w[2] = 16'h002A;
        chk_all("R2 write after wake-up pulse");

        // R3: sweep all writable registers with computed patterns
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 3; p++) begin
                d = 16'((r + 1) * 16'h1357 + p * 16'h2468) ^ 16'h8001;
                wr(map_a[r], d); exp_w[r] = d;
                chk_all("R3 write sweep");
            end
        end

        // R5: unmapped addresses leave every word unchanged
        foreach (map_a[i]) ;
        for (int k = 0; k < 7; k++) begin
            logic [6:0] ua;
            case (k)
                0: ua = 7'h01; 1: ua = 7'h12; 2: ua = 7'h18; 3: ua = 7'h38;
                4: ua = 7'h3F; 5: ua = 7'h41; default: ua = 7'h7E;
            endcase
            wr(ua, 16'hFFFF);
            chk_all("R5 unmapped write");
        end

        // R2: corrupted select bytes (each device bit, mode 00 and 10)
        for (int k = 0; k < 8; k++) begin
            logic [7:0] bad;
            if (k < 6) bad = SEL_WR ^ (8'h20 >> k);
            else if (k == 6) bad = SEL_WR & 8'h3F;
            else bad = (SEL_WR & 8'h3F) | 8'h80;
            send_sel(bad);
            send_byte(8'h11); send_byte(8'hBE); send_byte(8'hEF);
            chk_all("R2 rejected select");
        end

        // R4: bytes after a completed write are ignored
        wr(7'h10, 16'h0F0F); exp_w[1] = 16'h0F0F;
        send_byte(8'h00); send_byte(8'h55); send_byte(8'hAA);
        chk_all("R4 trailing bytes ignored");

        // R11: ninth clock edge coincident with the mode rise
        bmode = 1'b0; #HP;
        for (int i = 7; i >= 0; i--) bus_bit(SEL_WR[i]);
        bclk = 1'b0; bdin = 1'b1; #HP;
        bclk = 1'b1; bmode = 1'b1; #HP;
        send_byte({1'b0, 7'h11}); send_byte(8'h00); send_byte(8'h3C);
        exp_w[2] = 16'h003C;
        chk_all("R11 coincident edge");

        // R7: valid reads of both status words
        st_a = 16'hA55A; st_b = 16'h0000;
        prep(7'h18);
        rd(1'b0, 16'h0, got);
        chk("R7 read 18H", {8'h0, got}, {8'h0, 1'b0, 7'h18, 16'hA55A});
        st_b = 16'h1234;
        prep(7'h38);
        rd(1'b0, 16'h0, got);
        chk("R7 read 38H", {8'h0, got}, {8'h0, 1'b0, 7'h38, 16'h1234});
        chk("R10 R9 oe released", {31'h0, boe}, 32'h0);

        // R12: status change after the read select does not alter the reply
        rd(1'b1, 16'h7E7E, got);
        chk("R12 snapshot", {8'h0, got}, {8'h0, 1'b0, 7'h38, 16'h1234});

        // R8: prepare to a writable address is invalid
        prep(7'h10);
        rd(1'b0, 16'h0, got);
        chk("R8 invalid pointer", {8'h0, got}, {8'h0, 1'b1, 7'h10, 16'h0000});

        // R9: extra clocks after a reply keep the pad released
        bus_bit(1'b0); bus_bit(1'b0);
        chk("R9 no drive after reply", {31'h0, boe}, 32'h0);

        // R6: restore defaults
        wr(7'h7F, 16'hFFFF); set_defaults();
        chk_all("R6 restore");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule